// File: doc/BRIEF.md
# Secret Register Bank with Pseudo-Random Wipe

This block holds the secret words of a cipher unit: key, IV, data-in, data-out and the round state. Any of these five groups can be wiped, and a wipe fills each selected word with output from a 64-bit LFSR instead of zeros. A wipe starts in one of two ways. A clear command carries a group mask. A last-round strobe requests the state group only, so the round state never outlives the final round. Both use the same sweep engine, which writes one word per cycle and asserts a busy flag for the whole sweep.

The LFSR advances on every cycle. It can be reseeded through a request/acknowledge entropy interface, and the delivered entropy is folded into the LFSR state. Software writes any word through a write port. A software read returns real content only for the IV and data-out words. Every word is available on a flat internal bus that feeds the cipher datapath.

Top module: `secret_wipe_bank`

## Requirements
- R1: After reset all 24 words read zero on the internal bus, `clrBusy` and `entReq` are low, and the LFSR holds the seed 64'h5A3C_96E1_0F87_D24B.
- R2: The LFSR steps every cycle as next = {s[62:0], s[63]^s[62]^s[60]^s[59]}, and each wiped word receives bits [31:0] of the LFSR value present in the cycle of its write.
- R3: Group mask bits are: bit0 key (words 0-7), bit1 IV (8-11), bit2 data-in (12-15), bit3 data-out (16-19) and bit4 state (20-23). A clear command with a non-empty mask raises `clrBusy` in the next cycle. It then wipes the selected groups one word per cycle, in ascending group order and ascending word order, skipping unselected groups at no cost. `clrBusy` stays high for exactly as many cycles as there are selected words. Unselected words keep their values.
- R4: A last-round strobe wipes the state group through the same sweep, as if a clear command with mask bit4 had arrived.
- R5: A clear command with an empty mask starts nothing: `clrBusy` stays low and no word changes.
- R6: Software writes presented while `clrBusy` is high are dropped.
- R7: A software read of an IV or data-out word returns its content. A read of a key, data-in or state word, or of an unused address, returns zero.
- R8: A reseed pulse raises `entReq` in the next cycle, and `entReq` holds until `entAck` is seen. In the acknowledge cycle the LFSR loads step(s) XOR `entData`, and `entReq` is low from the next cycle on.
- R9: If the absorbed result would be all zeros, the LFSR loads the seed instead.
- R10: A clear command issued while a reseed is still pending proceeds at once with the current LFSR sequence, and the reseed request stays pending.
- R11: Clear commands or last-round strobes that arrive during a sweep are merged. Once the running sweep ends they are swept without a gap, and `clrBusy` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrReq | input | 1 | Clear command strobe |
| clrSel | input | 5 | Group mask for the clear command |
| lastRound | input | 1 | Final-round strobe that requests a state wipe |
| wrEn | input | 1 | Software write enable |
| wrAddr | input | 5 | Software write word index |
| wrData | input | 32 | Software write data |
| rdAddr | input | 5 | Software read word index |
| rdData | output | 32 | Software read data, filtered by group |
| reseedReq | input | 1 | Request an entropy reseed |
| entReq | output | 1 | Entropy request |
| entAck | input | 1 | Entropy acknowledge |
| entData | input | 64 | Entropy word, valid with entAck |
| clrBusy | output | 1 | A sweep is in progress |
| regsOut | output | 768 | All words flattened, word i at bits [32i+31:32i] |

## Verification
Each input is sampled at a rising edge, so `clrBusy` and `entReq` respond one cycle after their strobe. The k-th wiped word of a sweep lands k+1 edges after the edge that took the command. The read path is combinational. The bench drives inputs on falling edges and runs a cycle-accurate reference LFSR built from R2, R8 and R9. At the falling edge before each write edge, the driver queues the expected word with a due cycle one edge later. The monitor compares an item only once the cycle counter has reached that due cycle, so no comparison falls in the same instant as the write.

// File: rtl/secret_wipe_pkg.sv
package secret_wipe_pkg;

  localparam int LfsrW     = 64;
  localparam int NumGroups = 5;
  localparam int GrpW      = $clog2(NumGroups);
  localparam int StrbAddrW = 8;

  // group numbering is the sweep priority: lower number is wiped first
  localparam int GrpKey   = 0;
  localparam int GrpIv    = 1;
  localparam int GrpDin   = 2;
  localparam int GrpDout  = 3;
  localparam int GrpState = 4;

  typedef struct packed {
    logic                 busy;
    logic                 wipeEn;
    logic [StrbAddrW-1:0] wipeAddr;
    logic                 absorb;
  } wipeStrb_t;

  function automatic logic [LfsrW-1:0] lfsrStep(input logic [LfsrW-1:0] s);
    return {s[LfsrW-2:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

endpackage

// File: rtl/secret_wipe_ctrl.sv
module secret_wipe_ctrl
  import secret_wipe_pkg::*;
#(
  parameter int KeyWords  = 8,
  parameter int IvWords   = 4,
  parameter int DataWords = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clrReq,
  input  logic [NumGroups-1:0] clrSel,
  input  logic                 lastRound,
  input  logic                 reseedReq,
  input  logic                 entAck,
  output logic                 entReq,
  output wipeStrb_t            strb
);

  localparam int MaxA   = (KeyWords > IvWords) ? KeyWords : IvWords;
  localparam int MaxGrp = (MaxA > DataWords) ? MaxA : DataWords;
  localparam int IdxW   = $clog2(MaxGrp) + 1;
  localparam logic [NumGroups-1:0] StateBit = NumGroups'(1) << GrpState;

  function automatic int grpSize(input int g);
    case (g)
      GrpKey:  return KeyWords;
      GrpIv:   return IvWords;
      default: return DataWords;
    endcase
  endfunction

  function automatic int grpBase(input int g);
    int b;
    b = 0;
    for (int k = 0; k < NumGroups; k++) begin
      if (k < g) b += grpSize(k);
    end
    return b;
  endfunction

  logic                 busyQ;
  logic [NumGroups-1:0] actMask;
  logic [NumGroups-1:0] pendMask;
  logic [IdxW-1:0]      wordIdx;

  logic [NumGroups-1:0] reqMask;
  logic [NumGroups-1:0] remMask;
  logic [NumGroups-1:0] pendAll;
  logic [GrpW-1:0]      curGrp;
  logic [IdxW-1:0]      curSize;
  logic                 grpLast;

  // request decode and sweep position (R3, R4, R11)
  always_comb begin
    reqMask = ({NumGroups{clrReq}} & clrSel) | (lastRound ? StateBit : '0);
    curGrp  = '0;
    for (int g = NumGroups - 1; g >= 0; g--) begin
      if (actMask[g]) curGrp = GrpW'(g);
    end
    curSize = IdxW'(grpSize(int'(curGrp)));
    grpLast = (wordIdx == curSize - IdxW'(1));
    remMask = actMask & ~(NumGroups'(1) << curGrp);
    pendAll = pendMask | reqMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      actMask  <= '0;
      pendMask <= '0;
      wordIdx  <= '0;
    end else if (!busyQ) begin
      // empty request starts nothing (R5)
      if (reqMask != '0) begin
        busyQ   <= 1'b1;
        actMask <= reqMask;
        wordIdx <= '0;
      end
    end else if (!grpLast) begin
      wordIdx  <= wordIdx + IdxW'(1);
      pendMask <= pendAll;
    end else begin
      wordIdx <= '0;
      if (remMask != '0) begin
        actMask  <= remMask;
        pendMask <= pendAll;
      end else if (pendAll != '0) begin
        // merged requests follow without a gap (R11)
        actMask  <= pendAll;
        pendMask <= '0;
      end else begin
        busyQ    <= 1'b0;
        actMask  <= '0;
        pendMask <= '0;
      end
    end
  end

  // entropy handshake (R8), independent of the sweep (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 entReq <= 1'b0;
    else if (entReq && entAck) entReq <= 1'b0;
    else if (reseedReq)        entReq <= 1'b1;
  end

  always_comb begin
    strb.busy     = busyQ;
    strb.wipeEn   = busyQ;
    strb.wipeAddr = StrbAddrW'(grpBase(int'(curGrp)) + int'(wordIdx));
    strb.absorb   = entReq && entAck;
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && clrReq && clrSel != '0) |=> busyQ);

  p_lastround_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && lastRound && !clrReq) |=> (busyQ && strb.wipeAddr == StrbAddrW'(grpBase(GrpState))));

  p_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && clrReq && clrSel == '0 && !lastRound) |=> !busyQ);

  p_merge_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && reqMask != '0) |=> busyQ);

  p_req_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!entReq && reseedReq) |=> entReq);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (entReq && !entAck) |=> entReq);

  p_req_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (entReq && entAck) |=> !entReq);

  p_clear_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    (entReq && !entAck && !busyQ && clrReq && clrSel != '0) |=> (busyQ && entReq));

endmodule

// File: rtl/secret_wipe_datapath.sv
module secret_wipe_datapath
  import secret_wipe_pkg::*;
#(
  parameter int                 KeyWords  = 8,
  parameter int                 IvWords   = 4,
  parameter int                 DataWords = 4,
  parameter int                 WordW     = 32,
  parameter logic [LfsrW-1:0]   Seed      = 64'h5A3C_96E1_0F87_D24B,
  localparam int                NumWords  = KeyWords + IvWords + 3 * DataWords,
  localparam int                AddrW     = $clog2(NumWords)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wipeStrb_t                 strb,
  input  logic                      wrEn,
  input  logic [AddrW-1:0]          wrAddr,
  input  logic [WordW-1:0]          wrData,
  input  logic [AddrW-1:0]          rdAddr,
  output logic [WordW-1:0]          rdData,
  input  logic [LfsrW-1:0]          entData,
  output logic [NumWords*WordW-1:0] regsOut
);

  localparam int IvLo   = KeyWords;
  localparam int IvHi   = KeyWords + IvWords;
  localparam int DoutLo = KeyWords + IvWords + DataWords;
  localparam int DoutHi = DoutLo + DataWords;

  logic [WordW-1:0] regs [NumWords];
  logic [LfsrW-1:0] lfsr;
  logic [LfsrW-1:0] lfsrNext;
  logic [LfsrW-1:0] mixed;

  // PRNG: free-running, entropy folded in on acknowledge (R2, R8, R9)
  always_comb begin
    mixed    = lfsrStep(lfsr) ^ entData;
    lfsrNext = lfsrStep(lfsr);
    if (strb.absorb) lfsrNext = (mixed == '0) ? Seed : mixed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= Seed;
    else       lfsr <= lfsrNext;
  end

  // register file: wipe port wins, software port closed while busy (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumWords; i++) regs[i] <= '0;
    end else if (strb.wipeEn) begin
      regs[strb.wipeAddr[AddrW-1:0]] <= lfsr[WordW-1:0];
    end else if (wrEn && !strb.busy && int'(wrAddr) < NumWords) begin
      regs[wrAddr] <= wrData;
    end
  end

  // software read filter (R7)
  always_comb begin
    rdData = '0;
    if ((int'(rdAddr) >= IvLo && int'(rdAddr) < IvHi) ||
        (int'(rdAddr) >= DoutLo && int'(rdAddr) < DoutHi))
      rdData = regs[rdAddr];
  end

  for (genvar i = 0; i < NumWords; i++) begin : g_flat
    assign regsOut[i*WordW +: WordW] = regs[i];
  end

  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  p_sw_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && wrEn && int'(wrAddr) < NumWords &&
     !(strb.wipeEn && strb.wipeAddr == StrbAddrW'(wrAddr)))
    |=> regs[$past(wrAddr)] == $past(regs[wrAddr]));

endmodule

// File: rtl/secret_wipe_bank.sv
module secret_wipe_bank
  import secret_wipe_pkg::*;
#(
  parameter int               KeyWords  = 8,
  parameter int               IvWords   = 4,
  parameter int               DataWords = 4,
  parameter int               WordW     = 32,
  parameter logic [LfsrW-1:0] Seed      = 64'h5A3C_96E1_0F87_D24B,
  localparam int              NumWords  = KeyWords + IvWords + 3 * DataWords,
  localparam int              AddrW     = $clog2(NumWords)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      clrReq,
  input  logic [NumGroups-1:0]      clrSel,
  input  logic                      lastRound,
  input  logic                      wrEn,
  input  logic [AddrW-1:0]          wrAddr,
  input  logic [WordW-1:0]          wrData,
  input  logic [AddrW-1:0]          rdAddr,
  output logic [WordW-1:0]          rdData,
  input  logic                      reseedReq,
  output logic                      entReq,
  input  logic                      entAck,
  input  logic [LfsrW-1:0]          entData,
  output logic                      clrBusy,
  output logic [NumWords*WordW-1:0] regsOut
);

  wipeStrb_t strb;

  secret_wipe_ctrl #(
    .KeyWords(KeyWords), .IvWords(IvWords), .DataWords(DataWords)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .clrSel(clrSel),
    .lastRound(lastRound), .reseedReq(reseedReq), .entAck(entAck),
    .entReq(entReq), .strb(strb)
  );

  secret_wipe_datapath #(
    .KeyWords(KeyWords), .IvWords(IvWords), .DataWords(DataWords),
    .WordW(WordW), .Seed(Seed)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .entData(entData),
    .regsOut(regsOut)
  );

  assign clrBusy = strb.busy;

endmodule

// File: tb/secret_wipe_bank_test.sv
module secret_wipe_bank_test;

  localparam int          ClkPeriod = 10;
  localparam int          NumWords  = 24;
  localparam logic [63:0] Seed      = 64'h5A3C_96E1_0F87_D24B;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        clrReq = 1'b0, lastRound = 1'b0, wrEn = 1'b0;
  logic        reseedReq = 1'b0, entAck = 1'b0;
  logic [4:0]  clrSel = '0, wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [63:0] entData = '0;
  logic [31:0] rdData;
  logic        entReq, clrBusy;
  logic [NumWords*32-1:0] regsOut;

  int total = 0, fails = 0, cyc = 0;
  logic [63:0] mdl;
  logic        mdlReq;
  logic [31:0] shadow [NumWords];

  typedef struct { int due; int addr; logic [31:0] val; string tag; } item_t;
  item_t sb[$];

  secret_wipe_bank uut (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .clrSel(clrSel), .lastRound(lastRound),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .reseedReq(reseedReq), .entReq(entReq), .entAck(entAck), .entData(entData),
    .clrBusy(clrBusy), .regsOut(regsOut)
  );

  always #(ClkPeriod/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] stepf(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  // reference PRNG and handshake from R2, R8, R9
  always @(posedge clk) begin
    if (!rstN) begin
      mdl <= Seed; mdlReq <= 1'b0;
    end else begin
      if (mdlReq && entAck) begin
        mdl    <= ((stepf(mdl) ^ entData) == 64'd0) ? Seed : (stepf(mdl) ^ entData);
        mdlReq <= 1'b0;
      end else begin
        mdl <= stepf(mdl);
        if (reseedReq) mdlReq <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare wipe results once their write edge has passed
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      chk(regsOut[it.addr*32 +: 32] == it.val, it.tag, $sformatf("wipe word %0d", it.addr),
          64'(regsOut[it.addr*32 +: 32]), 64'(it.val));
      shadow[it.addr] = it.val;
    end
  end

  function automatic bit readable(input int a);
    return (a >= 8 && a < 12) || (a >= 16 && a < 20);
  endfunction

  function automatic int gSize(input int g);
    return (g == 0) ? 8 : 4;
  endfunction

  function automatic int gBase(input int g);
    return (g == 0) ? 0 : 8 + 4 * (g - 1);
  endfunction

  task automatic addList(input logic [4:0] m, ref int q[$]);
    for (int g = 0; g < 5; g++)
      if (m[g]) for (int w = 0; w < gSize(g); w++) q.push_back(gBase(g) + w);
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < NumWords; i++) begin
      chk(regsOut[i*32 +: 32] == shadow[i], req, $sformatf("bus word %0d", i),
          64'(regsOut[i*32 +: 32]), 64'(shadow[i]));
      rdAddr = 5'(i);
      #1;
      chk(rdData == (readable(i) ? shadow[i] : 32'd0), "R7", $sformatf("read word %0d", i),
          64'(rdData), 64'(readable(i) ? shadow[i] : 32'd0));
    end
  endtask

  task automatic wrWord(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    shadow[a] = d;
  endtask

  // driver: midKind 0 none, 1 clear command, 2 last-round strobe
  task automatic doClear(input logic [4:0] firstMask, input bit firstIsLast,
                         input int midKind, input logic [4:0] midMask, input int midStep,
                         input bit swEn, input int swAddr, input logic [31:0] swVal,
                         input string tag);
    int q[$];
    addList(firstIsLast ? 5'b10000 : firstMask, q);
    if (midKind != 0) addList(midKind == 2 ? 5'b10000 : midMask, q);
    @(negedge clk);
    if (firstIsLast) lastRound = 1'b1;
    else begin clrReq = 1'b1; clrSel = firstMask; end
    @(negedge clk);
    clrReq = 1'b0; lastRound = 1'b0; clrSel = '0;
    for (int i = 0; i < q.size(); i++) begin
      chk(clrBusy == 1'b1, (i == 0) ? "R3" : "R11", $sformatf("busy at step %0d", i),
          64'(clrBusy), 64'd1);
      if (midKind != 0 && i == midStep) begin
        if (midKind == 2) lastRound = 1'b1;
        else begin clrReq = 1'b1; clrSel = midMask; end
      end else begin
        clrReq = 1'b0; lastRound = 1'b0; clrSel = '0;
      end
      if (swEn && i == 0) begin
        wrEn = 1'b1; wrAddr = 5'(swAddr); wrData = swVal;
      end else wrEn = 1'b0;
      sb.push_back('{due: cyc + 1, addr: q[i], val: mdl[31:0], tag: tag});
      @(negedge clk);
    end
    clrReq = 1'b0; lastRound = 1'b0; wrEn = 1'b0;
    chk(clrBusy == 1'b0, "R3", "busy after sweep", 64'(clrBusy), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NumWords; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(clrBusy == 1'b0, "R1", "busy after reset", 64'(clrBusy), 64'd0);
    chk(entReq == 1'b0, "R1", "entReq after reset", 64'(entReq), 64'd0);
    checkAll("R1");

    for (int i = 0; i < NumWords; i++) wrWord(i, 32'hC0DE_0000 + 32'(i * 17));
    checkAll("R7");

    // R2 / R3 key only, then skipping groups
    doClear(5'b00001, 1'b0, 0, '0, 0, 1'b0, 0, '0, "R2");
    checkAll("R3");
    doClear(5'b01010, 1'b0, 0, '0, 0, 1'b0, 0, '0, "R3");
    checkAll("R3");

    // R4 last-round strobe
    doClear('0, 1'b1, 0, '0, 0, 1'b0, 0, '0, "R4");
    checkAll("R4");

    // R5 empty mask
    @(negedge clk); clrReq = 1'b1; clrSel = '0;
    @(negedge clk); clrReq = 1'b0;
    chk(clrBusy == 1'b0, "R5", "busy on empty mask", 64'(clrBusy), 64'd0);
    checkAll("R5");

    // R6 software write during sweep is dropped
    doClear(5'b00100, 1'b0, 0, '0, 0, 1'b1, 9, 32'hDEAD_BEEF, "R6");
    checkAll("R6");

    // R8 reseed handshake and absorption
    @(negedge clk); reseedReq = 1'b1;
    @(negedge clk); reseedReq = 1'b0;
    chk(entReq == 1'b1, "R8", "entReq rise", 64'(entReq), 64'd1);
    repeat (3) @(negedge clk);
    chk(entReq == 1'b1, "R8", "entReq hold", 64'(entReq), 64'd1);
    entAck = 1'b1; entData = 64'hF00D_1234_5678_9ABC;
    @(negedge clk); entAck = 1'b0;
    chk(entReq == 1'b0, "R8", "entReq drop", 64'(entReq), 64'd0);
    doClear(5'b00100, 1'b0, 0, '0, 0, 1'b0, 0, '0, "R8");
    checkAll("R8");

    // R9 zero result replaced by seed
    @(negedge clk); reseedReq = 1'b1;
    @(negedge clk); reseedReq = 1'b0;
    entAck = 1'b1; entData = stepf(mdl);
    @(negedge clk); entAck = 1'b0;
    doClear(5'b00001, 1'b0, 0, '0, 0, 1'b0, 0, '0, "R9");
    checkAll("R9");

    // R10 clear while reseed pending
    @(negedge clk); reseedReq = 1'b1;
    @(negedge clk); reseedReq = 1'b0;
    doClear(5'b00010, 1'b0, 0, '0, 0, 1'b0, 0, '0, "R10");
    chk(entReq == 1'b1, "R10", "reseed still pending", 64'(entReq), 64'd1);
    entAck = 1'b1; entData = 64'h0123_4567_0000_FFFF;
    @(negedge clk); entAck = 1'b0;
    doClear(5'b01000, 1'b0, 0, '0, 0, 1'b0, 0, '0, "R10");
    checkAll("R10");

    // R11 merged requests: last-round mid-sweep, then clear on final step
    doClear(5'b00001, 1'b0, 2, '0, 3, 1'b0, 0, '0, "R11");
    checkAll("R11");
    doClear(5'b00010, 1'b0, 1, 5'b00101, 3, 1'b0, 0, '0, "R11");
    checkAll("R11");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

endmodule